// File: doc/BRIEF.md
# Binary Epoch Real-Time Counter

This block keeps time as one free-running binary number, with no calendar fields. A one-cycle enable pulse for each oscillator period (32768 Hz) advances a sub-second counter. When that counter wraps, it carries into a seconds counter. Software sets wall time by loading an offset, which is added to the count. The running counter is never written. Converting the count to dates is left to software.

The CPU does not read the live counters. It reads a shadow set: sub-second, seconds, and the offset-corrected wall time. The shadow set is refreshed once every 256 oscillator periods, which is about 7.8 ms at the default sizes. A read sequence that starts at the sub-second word holds the shadow set still until the sequence reaches the top wall word, so a carry cannot tear the value. While the chip sleeps the shadow set is not refreshed. After wake, a stale flag shows that the shadow set is old until the next refresh.

Register access uses a request/response handshake. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high only while no response is waiting, so at most one transaction is in flight. Each request gets exactly one response. `rsp_valid` and `rsp_data` hold steady until `rsp_ready` is high, so the reader can apply back-pressure for as long as it needs. Write requests answer with data 0.

Top module: `rtc_epoch_top`

## Requirements
- R1: After reset the shadow words, the active offset and the overflow flag are zero, status reads 0x1 (stale set, all else clear), `alarm_irq` is low and no response is pending.
- R2: Each `osc_tick` pulse advances the SUB_W-bit (default 15) sub-second count by one. On wrap it goes to 0 and the SEC_W-bit (default 32) seconds count advances by one. Without a pulse both counts hold.
- R3: A tick that brings the low DIV_LOG2 (default 8) bits of the sub-second count to zero refreshes the shadow set from the new count, visible two cycles later. At no other time does the shadow set change. Address 0 reads the shadow sub-second and address 1 the shadow seconds, both zero-extended.
- R4: The shadow wall time equals the active offset plus the count {seconds, sub-second}, modulo 2^OFS_W (OFS_W default 48). Address 2 returns its bits 31:0 and address 3 its upper bits, zero-extended.
- R5: A read of address 0 freezes the shadow set. Refreshes are skipped until a read of address 3 is accepted.
- R6: While `sleep` is high no refresh happens. A falling edge of `sleep` sets the stale flag (status bit 0), which clears at the next refresh.
- R7: Writes to address 4 (offset bits 31:0) and address 5 (upper offset bits) fill a staging copy. A write to address 5 sets the pending flag (status bit 1). The active offset, which reads back at addresses 4 and 5, takes the staged value only at the next refresh, and the pending flag clears then.
- R8: When the seconds count wraps from all ones to zero, the sticky overflow flag (status bit 2) is set. Writing status (address 6) with bit 2 set clears it. The other written bits have no effect.
- R9: Address 7 holds the alarm seconds value and bit 0 of address 8 enables the alarm. `alarm_irq` is high, and status bit 3 reads 1, exactly while the alarm is enabled and the live seconds count equals the alarm value.
- R10: `req_ready` is low while a response waits. `rsp_valid` and `rsp_data` hold until `rsp_ready` is high. Writes respond with 0, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| sleep | input | 1 | Deep-sleep level; its falling edge marks wake |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken this cycle if valid |
| rsp_data | output | 32 | Read data (0 for writes) |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
The checks aim at how a corrupted internal state would show up at the ports, and how soon. A wrong live count stays hidden until the next refresh. After that it shows in the sub-second and seconds words and in the carry into the upper wall word, within one divided period. A freeze or sleep gate that leaks shows as shadow words that change between the first and last reads of a sequence. A pending offset applied too early shows in the offset read-back before any tick. Overflow and alarm faults appear in the status word and on `alarm_irq` in the cycle after the seconds count reaches the value in question.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_SH_SUB  = 4'd0;
  localparam logic [ADDR_W-1:0] A_SH_SEC  = 4'd1;
  localparam logic [ADDR_W-1:0] A_WALL_LO = 4'd2;
  localparam logic [ADDR_W-1:0] A_WALL_HI = 4'd3;
  localparam logic [ADDR_W-1:0] A_OFS_LO  = 4'd4;
  localparam logic [ADDR_W-1:0] A_OFS_HI  = 4'd5;
  localparam logic [ADDR_W-1:0] A_STATUS  = 4'd6;
  localparam logic [ADDR_W-1:0] A_ALM_VAL = 4'd7;
  localparam logic [ADDR_W-1:0] A_ALM_EN  = 4'd8;

  localparam int ST_OVF_BIT = 2;

  typedef struct packed {
    logic alarm;
    logic ovf;
    logic pending;
    logic stale;
  } rtc_status_t;
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int SUB_W    = 15,
  parameter int SEC_W    = 32,
  parameter int DIV_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  output logic [SUB_W-1:0] sub_cnt,
  output logic [SEC_W-1:0] sec_cnt,
  output logic             div_tick,
  output logic             sec_wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_cnt  <= '0;
      sec_cnt  <= '0;
      div_tick <= 1'b0;
      sec_wrap <= 1'b0;
    end else begin
      div_tick <= 1'b0;
      sec_wrap <= 1'b0;
      if (osc_tick) begin
        div_tick <= &sub_cnt[DIV_LOG2-1:0];
        if (&sub_cnt) begin
          sub_cnt  <= '0;
          sec_cnt  <= sec_cnt + 1'b1;
          sec_wrap <= &sec_cnt;
        end else begin
          sub_cnt <= sub_cnt + 1'b1;
        end
      end
    end
  end

  AST_SUB_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_tick && (&sub_cnt)) |=> (sub_cnt == '0 && sec_cnt == $past(sec_cnt) + 1'b1)); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> ($stable(sub_cnt) && $stable(sec_cnt))); // R2
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow #(
  parameter int SUB_W    = 15,
  parameter int SEC_W    = 32,
  parameter int OFS_W    = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_tick,
  input  logic             sleep,
  input  logic             freeze,
  input  logic [SUB_W-1:0] sub_cnt,
  input  logic [SEC_W-1:0] sec_cnt,
  input  logic [OFS_W-1:0] ofs_stage,
  input  logic             ofs_load,
  output logic [SUB_W-1:0] sh_sub,
  output logic [SEC_W-1:0] sh_sec,
  output logic [OFS_W-1:0] sh_wall,
  output logic [OFS_W-1:0] ofs_act,
  output logic             pending,
  output logic             stale
);
  logic             sleep_q;
  logic             wake;
  logic             refresh;
  logic [OFS_W-1:0] ofs_next;

  assign wake     = sleep_q && !sleep;
  assign refresh  = div_tick && !freeze && !sleep;
  assign ofs_next = pending ? ofs_stage : ofs_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      sh_sub  <= '0;
      sh_sec  <= '0;
      sh_wall <= '0;
      ofs_act <= '0;
      pending <= 1'b0;
      stale   <= 1'b1;
    end else begin
      sleep_q <= sleep;
      if (refresh) begin
        sh_sub  <= sub_cnt;
        sh_sec  <= sec_cnt;
        ofs_act <= ofs_next;
        sh_wall <= ofs_next + OFS_W'({sec_cnt, sub_cnt});
      end
      if (ofs_load)     pending <= 1'b1;
      else if (refresh) pending <= 1'b0;
      if (wake)         stale <= 1'b1;
      else if (refresh) stale <= 1'b0;
    end
  end

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(sh_sec) && $stable(sh_wall) && $stable(sh_sub))); // R5
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(sh_sec) && $stable(sh_sub))); // R6
  AST_STALE_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_q && !sleep) |=> stale); // R6
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && !ofs_load) |=> !pending); // R7
endmodule

// File: rtl/rtc_regif.sv
module rtc_regif
  import rtc_pkg::*;
#(
  parameter int SUB_W = 15,
  parameter int SEC_W = 32,
  parameter int OFS_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [SUB_W-1:0]  sh_sub,
  input  logic [SEC_W-1:0]  sh_sec,
  input  logic [OFS_W-1:0]  sh_wall,
  input  logic [OFS_W-1:0]  ofs_act,
  input  logic              pending,
  input  logic              stale,
  input  logic              sec_wrap,
  input  logic [SEC_W-1:0]  sec_cnt,
  output logic              freeze,
  output logic [OFS_W-1:0]  ofs_stage,
  output logic              ofs_load,
  output logic              alarm_irq
);
  localparam int HI_W = OFS_W - DATA_W;

  logic              accept;
  logic              ovf_clr;
  logic              ovf;
  logic [SEC_W-1:0]  alm_val;
  logic              alm_en;
  logic [DATA_W-1:0] rd_mux;
  rtc_status_t       status;

  assign req_ready = !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign ovf_clr   = accept && req_write && req_addr == A_STATUS && req_wdata[ST_OVF_BIT];
  assign alarm_irq = alm_en && (sec_cnt == alm_val);
  assign status    = '{alarm: alarm_irq, ovf: ovf, pending: pending, stale: stale};

  always_comb begin
    rd_mux = '0;
    case (req_addr)
      A_SH_SUB:  rd_mux = DATA_W'(sh_sub);
      A_SH_SEC:  rd_mux = DATA_W'(sh_sec);
      A_WALL_LO: rd_mux = sh_wall[DATA_W-1:0];
      A_WALL_HI: rd_mux = DATA_W'(sh_wall[OFS_W-1:DATA_W]);
      A_OFS_LO:  rd_mux = ofs_act[DATA_W-1:0];
      A_OFS_HI:  rd_mux = DATA_W'(ofs_act[OFS_W-1:DATA_W]);
      A_STATUS:  rd_mux = DATA_W'(status);
      A_ALM_VAL: rd_mux = DATA_W'(alm_val);
      A_ALM_EN:  rd_mux = DATA_W'(alm_en);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      freeze    <= 1'b0;
      ofs_stage <= '0;
      ofs_load  <= 1'b0;
      ovf       <= 1'b0;
      alm_val   <= '0;
      alm_en    <= 1'b0;
    end else begin
      ofs_load <= 1'b0;
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_data  <= req_write ? '0 : rd_mux;
        if (req_write) begin
          case (req_addr)
            A_OFS_LO:  ofs_stage[DATA_W-1:0] <= req_wdata;
            A_OFS_HI: begin
              ofs_stage[OFS_W-1:DATA_W] <= req_wdata[HI_W-1:0];
              ofs_load <= 1'b1;
            end
            A_ALM_VAL: alm_val <= req_wdata[SEC_W-1:0];
            A_ALM_EN:  alm_en  <= req_wdata[0];
            default: ;
          endcase
        end else begin
          if (req_addr == A_SH_SUB)  freeze <= 1'b1;
          if (req_addr == A_WALL_HI) freeze <= 1'b0;
        end
      end
      if (sec_wrap)     ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf); // R8
  AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wrap |=> ovf); // R8
endmodule

// File: rtl/rtc_epoch_top.sv
module rtc_epoch_top
  import rtc_pkg::*;
#(
  parameter int SUB_W    = 15,
  parameter int SEC_W    = 32,
  parameter int OFS_W    = 48,
  parameter int DIV_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              sleep,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              alarm_irq
);
  logic [SUB_W-1:0] sub_cnt, sh_sub;
  logic [SEC_W-1:0] sec_cnt, sh_sec;
  logic [OFS_W-1:0] sh_wall, ofs_act, ofs_stage;
  logic             div_tick, sec_wrap, freeze, ofs_load, pending, stale;

  rtc_counter #(.SUB_W(SUB_W), .SEC_W(SEC_W), .DIV_LOG2(DIV_LOG2)) u_cnt (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .sub_cnt(sub_cnt), .sec_cnt(sec_cnt), .div_tick(div_tick), .sec_wrap(sec_wrap)
  );

  rtc_shadow #(.SUB_W(SUB_W), .SEC_W(SEC_W), .OFS_W(OFS_W)) u_shd (
    .clk(clk), .rst_n(rst_n), .div_tick(div_tick), .sleep(sleep), .freeze(freeze),
    .sub_cnt(sub_cnt), .sec_cnt(sec_cnt), .ofs_stage(ofs_stage), .ofs_load(ofs_load),
    .sh_sub(sh_sub), .sh_sec(sh_sec), .sh_wall(sh_wall), .ofs_act(ofs_act),
    .pending(pending), .stale(stale)
  );

  rtc_regif #(.SUB_W(SUB_W), .SEC_W(SEC_W), .OFS_W(OFS_W)) u_reg (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .sh_sub(sh_sub), .sh_sec(sh_sec), .sh_wall(sh_wall), .ofs_act(ofs_act),
    .pending(pending), .stale(stale), .sec_wrap(sec_wrap), .sec_cnt(sec_cnt),
    .freeze(freeze), .ofs_stage(ofs_stage), .ofs_load(ofs_load), .alarm_irq(alarm_irq)
  );
endmodule

// File: tb/tb_rtc_epoch_top.sv
module tb_rtc_epoch_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_tick = 1'b0;
  logic        sleep = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, alarm_irq;
  logic [31:0] rsp_data;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  rtc_epoch_top #(.SUB_W(6), .SEC_W(6), .OFS_W(48), .DIV_LOG2(3)) dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sleep(sleep),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .alarm_irq(alarm_irq)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations as responses are handed over
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) check(rsp_data, 32'hDEAD_BEEF, "R10 unexpected response");
        else check(rsp_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic xfer(input logic wr, input logic [3:0] a, input logic [31:0] d,
                      input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    xfer(1'b0, a, 32'h0, exp, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    xfer(1'b1, a, d, 32'h0, tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1;
    osc_tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 osc_tick = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic rd_seq(input logic [31:0] s, input logic [31:0] c,
                        input logic [31:0] lo, input logic [31:0] hi, input string tag);
    rd(4'd0, s, {tag, " sub"});
    rd(4'd1, c, {tag, " sec"});
    rd(4'd2, lo, {tag, " wall lo"});
    rd(4'd3, hi, {tag, " wall hi"});
    drain();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check({31'b0, alarm_irq}, 32'h0, "R1 irq after reset");
    check({31'b0, rsp_valid}, 32'h0, "R1 no response after reset");
    rd(4'd6, 32'h1, "R1 status after reset");
    rd(4'd4, 32'h0, "R1 offset lo after reset");
    rd_seq(0, 0, 0, 0, "R1 reset shadow");

    // T=200: sub 8, sec 3
    ticks(200);
    rd(4'd6, 32'h0, "R6 stale cleared by refresh");
    rd_seq(8, 3, 200, 0, "R2 R3 count after 200 ticks");

    // offset write, staged
    wr(4'd4, 32'hFFFF_FFF0, "R7 write offset lo");
    wr(4'd5, 32'h0000_0001, "R7 write offset hi");
    rd(4'd6, 32'h2, "R7 pending set");
    rd(4'd4, 32'h0, "R7 active offset unchanged before refresh");
    drain();
    ticks(8); // T=208
    rd(4'd6, 32'h0, "R7 pending cleared");
    rd(4'd4, 32'hFFFF_FFF0, "R7 active offset lo");
    rd(4'd5, 32'h1, "R7 active offset hi");
    rd_seq(16, 3, 32'hC0, 2, "R4 wall with offset carry");

    // freeze across a seconds carry
    rd(4'd0, 16, "R5 sub starts sequence");
    drain();
    ticks(64); // T=272
    rd(4'd1, 3, "R5 frozen sec");
    rd(4'd2, 32'hC0, "R5 frozen wall lo");
    rd(4'd3, 2, "R5 frozen wall hi");
    drain();
    ticks(8); // T=280
    rd_seq(24, 4, 32'h108, 2, "R5 released refresh");

    // sleep
    @(posedge clk); #1 sleep = 1'b1;
    ticks(16); // T=296
    rd(4'd6, 32'h0, "R6 no stale while asleep");
    rd_seq(24, 4, 32'h108, 2, "R6 no refresh in sleep");
    @(posedge clk); #1 sleep = 1'b0;
    repeat (3) @(posedge clk);
    rd(4'd6, 32'h1, "R6 stale after wake");
    drain();
    ticks(8); // T=304
    rd(4'd6, 32'h0, "R6 stale cleared after wake refresh");
    rd_seq(48, 4, 32'h120, 2, "R3 refresh after wake");

    // alarm at second 6
    wr(4'd7, 32'd6, "R9 alarm value");
    wr(4'd8, 32'd1, "R9 alarm enable");
    drain();
    @(negedge clk);
    check({31'b0, alarm_irq}, 32'h0, "R9 irq low before match");
    ticks(80); // T=384, sec 6
    @(negedge clk);
    check({31'b0, alarm_irq}, 32'h1, "R9 irq on match");
    rd(4'd6, 32'h8, "R9 status alarm bit");
    drain();
    ticks(64); // T=448, sec 7
    @(negedge clk);
    check({31'b0, alarm_irq}, 32'h0, "R9 irq low after match");

    // seconds wrap at T=4096
    ticks(4096 - 448);
    rd(4'd6, 32'h4, "R8 overflow set on wrap");
    rd_seq(0, 0, 32'hFFFF_FFF0, 1, "R8 R4 count wrapped");
    wr(4'd6, 32'h1, "R8 write without bit2");
    rd(4'd6, 32'h4, "R8 overflow kept");
    wr(4'd6, 32'h4, "R8 write one to clear");
    rd(4'd6, 32'h0, "R8 overflow cleared");
    rd(4'd15, 32'h0, "R10 unmapped read");
    drain();

    // back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    rd(4'd7, 32'd6, "R10 held response data");
    repeat (4) @(negedge clk);
    check({31'b0, rsp_valid}, 32'h1, "R10 rsp_valid held");
    check({31'b0, req_ready}, 32'h0, "R10 req_ready low while waiting");
    @(posedge clk); #1 rsp_ready = 1'b1;
    drain();

    summary();
    $finish;
  end
endmodule